// File: doc/BRIEF.md
# Register-Pair Rotator with Field Mask

This unit forms a 72-bit word from two 36-bit operands, with the P operand in the upper half and the Q operand in the lower half. It rotates that word by a signed cycle amount and takes the upper 36 bits of the rotated word as a field. A mask whose ones fill the low bits, of selectable width, is ANDed onto that field. The masked field is written into the P register at the next clock edge. Field extraction, shifts across the word pair and byte handling each take one load.

The cycle amount is a 7-bit two's-complement code. Only the values from -3 to +39 are accepted. A code outside that window leaves P untouched and raises an error flag. The Q operand is only read. The path from the operands to the register has no pipeline stage, so a result appears on the output one edge after `load_en` is sampled high.

Top module: `pair_cycle_mask`

## Requirements
- R1: While `rst_n` is low, `p_out` is all zeros and `amt_err` is 0.
- R2: For a legal amount n from 0 to 39, the field is the upper 36 bits of `{p_in, q_in}` rotated left by n. Field bit i is bit ((36+i-n) mod 72) of the pair, where pair bits 71..36 are `p_in` and 35..0 are `q_in`.
- R3: For a negative amount n from -1 to -3, the pair is rotated right by |n| before the upper 36 bits are taken. This is the same formula as R2 with n negative.
- R4: `cyc_amt` is read as 7-bit two's complement. A load whose amount lies outside -3..+39 leaves `p_out` unchanged and sets `amt_err` to 1 after that edge.
- R5: A load with a legal amount sets `amt_err` to 0 after that edge.
- R6: Mask width w (`mask_w`, unsigned) keeps field bits 0..w-1 and clears the rest. Width 0 gives all zeros. Width 36 passes the whole field. Any width above 36 acts as 36.
- R7: While `load_en` is low, `p_out` and `amt_err` hold their values, whatever the other inputs do.
- R8: The masked field of a legal load appears on `p_out` after the first rising edge at which `load_en` is sampled high, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write the masked field into P at this edge |
| p_in | input | 36 | Upper half of the rotated pair |
| q_in | input | 36 | Lower half of the rotated pair, read only |
| cyc_amt | input | 7 | Signed cycle amount, two's complement |
| mask_w | input | 6 | Number of low field bits kept |
| p_out | output | 36 | The P register |
| amt_err | output | 1 | Last load carried an illegal amount |

## Verification
Amount range checking and writeback take place in the same cycle. In an illegal-amount cycle a valid rotated and masked field is present at the register input, and the check must discard it while it sets the flag. The bench sweeps all 128 amount codes back to back with full width, which places illegal codes directly after legal ones and the reverse. At each edge it judges `p_out` against either the independently computed field or the value held from the previous edge. The legal/illegal decision is taken from the -3..+39 window. Width 0 paired with a legal amount is also driven, to separate the zero result of masking from the hold caused by an error.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  parameter int WORD_W  = 36;
  parameter int AMT_W   = 7;
  parameter int WID_W   = 6;
  parameter int MIN_AMT = -3;
  parameter int MAX_AMT = 39;
  localparam int PAIR_W = 2 * WORD_W;
  localparam int ROT_W  = $clog2(PAIR_W);

  // upper word of a left rotation of the pair by k (0..PAIR_W-1)
  function automatic logic [WORD_W-1:0] upper_of_rotl(
      input logic [PAIR_W-1:0] pair, input logic [ROT_W-1:0] k);
    logic [2*PAIR_W-1:0] dbl;
    dbl = {pair, pair} << k;
    return dbl[2*PAIR_W-1 -: WORD_W];
  endfunction

  // normalise a signed amount to a left rotation count
  function automatic logic [ROT_W-1:0] left_count(input int n);
    int t;
    t = (n < 0) ? n + PAIR_W : n;
    return ROT_W'(t);
  endfunction
endpackage

// File: rtl/rm_amount_decode.sv
module rm_amount_decode
  import rotmask_pkg::*;
#(
  parameter int A_W  = AMT_W,
  parameter int LO   = MIN_AMT,
  parameter int HI   = MAX_AMT,
  localparam int K_W = ROT_W
) (
  input  logic [A_W-1:0] amt_i,
  output logic           legal_o,
  output logic [K_W-1:0] k_o
);
  logic signed [A_W-1:0] s_amt;
  int                    n_int;

  always_comb begin
    s_amt   = amt_i;
    n_int   = int'(s_amt);
    legal_o = (n_int >= LO) && (n_int <= HI);
    k_o     = legal_o ? left_count(n_int) : '0;
  end
endmodule

// File: rtl/rm_cycler.sv
module rm_cycler
  import rotmask_pkg::*;
#(
  parameter int W    = WORD_W,
  localparam int PW  = 2 * W,
  localparam int K_W = $clog2(PW)
) (
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [K_W-1:0] k_i,
  output logic [W-1:0]   field_o
);
  logic [PW-1:0] pair;
  assign pair    = {hi_i, lo_i};
  assign field_o = upper_of_rotl(pair, k_i);
endmodule

// File: rtl/rm_masker.sv
module rm_masker
  import rotmask_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int WW  = WID_W
) (
  input  logic [W-1:0]  field_i,
  input  logic [WW-1:0] width_i,
  output logic [W-1:0]  masked_o
);
  logic [WW-1:0] w_clamped;
  logic [W-1:0]  mask;

  assign w_clamped = (width_i >= WW'(W)) ? WW'(W) : width_i;

  for (genvar i = 0; i < W; i++) begin : g_mask_bit
    assign mask[i] = (w_clamped > WW'(i));
  end

  assign masked_o = field_i & mask;
endmodule

// File: rtl/pair_cycle_mask.sv
module pair_cycle_mask
  import rotmask_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int A_W  = AMT_W,
  parameter int WW   = WID_W,
  localparam int K_W = $clog2(2 * W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [W-1:0]  p_in,
  input  logic [W-1:0]  q_in,
  input  logic [A_W-1:0] cyc_amt,
  input  logic [WW-1:0] mask_w,
  output logic [W-1:0]  p_out,
  output logic          amt_err
);
  logic           amt_legal;
  logic [K_W-1:0] rot_k;
  logic [W-1:0]   rot_field;
  logic [W-1:0]   next_p;
  logic           do_write;
  logic           do_reject;

  rm_amount_decode #(.A_W(A_W)) u_dec (
    .amt_i  (cyc_amt),
    .legal_o(amt_legal),
    .k_o    (rot_k)
  );

  rm_cycler #(.W(W)) u_cyc (
    .hi_i   (p_in),
    .lo_i   (q_in),
    .k_i    (rot_k),
    .field_o(rot_field)
  );

  rm_masker #(.W(W), .WW(WW)) u_msk (
    .field_i (rot_field),
    .width_i (mask_w),
    .masked_o(next_p)
  );

  assign do_write  = load_en && amt_legal;
  assign do_reject = load_en && !amt_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_out   <= '0;
      amt_err <= 1'b0;
    end else if (load_en) begin
      amt_err <= do_reject;
      if (do_write) p_out <= next_p;
    end
  end

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(p_out) && $stable(amt_err)));

  p_bad_amount_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !amt_legal) |=> ($stable(p_out) && amt_err));

  p_good_amount_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && amt_legal) |=> !amt_err);

  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && amt_legal && mask_w == '0) |=> (p_out == '0));

  p_field_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && amt_legal && mask_w < WW'(W)) |=> ((p_out >> $past(mask_w)) == '0));
endmodule

// File: tb/sim_pair_cycle_mask.sv
module sim_pair_cycle_mask;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [35:0] p_in = '0;
  logic [35:0] q_in = '0;
  logic [6:0]  cyc_amt = '0;
  logic [5:0]  mask_w = '0;
  logic [35:0] p_out;
  logic        amt_err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [35:0] exp_p = '0;
  logic        exp_e = 1'b0;

  pair_cycle_mask u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .p_in(p_in), .q_in(q_in),
    .cyc_amt(cyc_amt), .mask_w(mask_w), .p_out(p_out), .amt_err(amt_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus table: P, Q, amount code, width, expected error flag
  localparam logic [35:0] TP [NV] = '{36'h123456789, 36'h800000001, 36'hFEDCBA987,
    36'h0F0F0F0F0, 36'hABCDEF012, 36'h555555555, 36'hFFFFFFFFF, 36'h13579BDF1,
    36'h2468ACE02, 36'hC3C3C3C3C, 36'h000000FFF, 36'h9ABCDEF01};
  localparam logic [35:0] TQ [NV] = '{36'hABCDEF012, 36'h000000003, 36'h012345678,
    36'hF0F0F0F0F, 36'h876543210, 36'hAAAAAAAAA, 36'h000000000, 36'hFDB975310,
    36'h111111111, 36'h3C3C3C3C3, 36'hFFF000000, 36'h765432100};
  localparam logic [6:0] TA [NV] = '{7'd0, 7'd1, 7'd39, 7'h7F, 7'h7D, 7'd36,
    7'd12, 7'h7C, 7'd40, 7'd35, 7'h40, 7'd8};
  localparam logic [5:0] TW [NV] = '{6'd36, 6'd8, 6'd36, 6'd36, 6'd12, 6'd0,
    6'd63, 6'd5, 6'd36, 6'd37, 6'd36, 6'd1};
  localparam logic TE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  // reference: bit i of field comes from pair index (36+i-n) mod 72
  function automatic logic [35:0] ref_field(input logic [35:0] p, input logic [35:0] q,
                                           input int n, input int w);
    logic [35:0] r;
    int idx;
    int wl;
    wl = (w > 36) ? 36 : w;
    for (int i = 0; i < 36; i++) begin
      idx = ((36 + i - n) % 72 + 72) % 72;
      r[i] = (i < wl) ? ((idx >= 36) ? p[idx-36] : q[idx]) : 1'b0;
    end
    return r;
  endfunction

  function automatic int code_to_int(input logic [6:0] c);
    return (c[6]) ? int'(c) - 128 : int'(c);
  endfunction

  task automatic check(input string req, input logic [35:0] ep, input logic ee);
    n_checks++;
    if (p_out !== ep || amt_err !== ee) begin
      n_fail++;
      $display("FAIL %s: p_out=%h err=%b expected p_out=%h err=%b", req, p_out, amt_err, ep, ee);
    end
  endtask

  // one load, result judged after the edge (R8 timing)
  task automatic do_load(input string req, input logic [35:0] p, input logic [35:0] q,
                         input logic [6:0] a, input logic [5:0] w, input logic e_known, input logic e_val);
    int n;
    logic bad;
    @(negedge clk);
    p_in = p; q_in = q; cyc_amt = a; mask_w = w; load_en = 1'b1;
    n = code_to_int(a);
    bad = e_known ? e_val : ((n < -3) || (n > 39));
    if (!bad) exp_p = ref_field(p, q, n, int'(w));
    exp_e = bad;
    @(posedge clk);
    #1;
    check(req, exp_p, exp_e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", 36'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R2, R3, R4, R5, R6, R8
    for (int v = 0; v < NV; v++) begin
      do_load((TE[v]) ? "R4" : ((code_to_int(TA[v]) < 0) ? "R3" : "R2"),
              TP[v], TQ[v], TA[v], TW[v], 1'b1, TE[v]);
    end

    // R6: zero width right after an illegal load gives zero and clears flag (R5)
    do_load("R4", 36'hFFFFFFFFF, 36'hFFFFFFFFF, 7'd50, 6'd36, 1'b1, 1'b1);
    do_load("R6", 36'hFFFFFFFFF, 36'hFFFFFFFFF, 7'd3, 6'd0, 1'b1, 1'b0);
    do_load("R6", 36'hFFFFFFFFF, 36'hFFFFFFFFF, 7'd3, 6'd36, 1'b1, 1'b0);
    do_load("R5", 36'h00000000F, 36'h0, 7'h7E, 6'd4, 1'b1, 1'b0);

    // R7: no load, inputs wiggle, state holds (first make err set)
    do_load("R4", 36'h1, 36'h2, 7'h7B, 6'd36, 1'b1, 1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      load_en = 1'b0;
      p_in = ~p_in ^ 36'(c); q_in = ~q_in; cyc_amt = 7'd5; mask_w = 6'd36;
      @(posedge clk);
      #1;
      check("R7", exp_p, exp_e);
    end

    // sweep of all amount codes back to back: R2, R3, R4
    for (int a = 0; a < 128; a++) begin
      do_load("R4/R2/R3 sweep", 36'h8C3A5F017, 36'h4E1D29B6C, 7'(a), 6'd36, 1'b0, 1'b0);
    end

    // R1 again: asynchronous reset mid-run
    @(negedge clk);
    load_en = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", 36'h0, 1'b0);
    summary();
  end
endmodule